// File: doc/BRIEF.md
# Bandwidth Usage Monitor Controller

This block is a command engine for a bank of bandwidth usage counters, one per monitoring ID. Software writes a 64-bit control word that names an operation, a monitoring ID, an event selector and an optional access type. In the same clock edge the block checks the request in a fixed order. It then either programs the selected counter slot or copies the slot into a read-only counter-value register. The outcome goes into a status field of the control register, where software reads it back.

A side-band traffic port reports transfers as a byte count, a direction, a monitoring ID and an access type. On every reported transfer, each active slot that matches the ID, the direction rule of its event and its access-type filter adds the byte count. A slot that has just been programmed carries an INVALID flag until its first counted transfer. A counter that wraps raises a sticky overflow flag and keeps counting modulo its width. The counter width is a parameter of at most 62 bits. Above it, the counter-value field reads as zero.

Top module: `bwmon_ctrl`

## Requirements
- R1: After reset, the control register (offset 8) and the counter-value register (offset 16) both read as 0.
- R2: The control register holds OP[4:0], AT[7:5], MCID[19:8], EVT[27:20], ATV[28], STATUS[38:32] and BUSY[39], with all other bits zero. STATUS and BUSY ignore written data. Writes to offset 16 and to unmapped or unaligned offsets change nothing. Unmapped and unaligned offsets read as 0.
- R3: An MCID greater than or equal to NUM_MON gives status 3 whatever the operation, and no slot changes.
- R4: OP 1 configures and OP 2 reads a counter. Any other OP, or one disabled by parameter, gives status 2. A command that is accepted gives status 1.
- R5: A configure with EVT 0 makes the slot inactive and returns status 1. An inactive slot counts nothing. An EVT above 3 gives status 4, and the event check comes before the access-type check.
- R6: A configure with EVT 1, 2 or 3 clears the count and OVF, sets INVALID and makes the slot active. It also records the access type, or "any" when ATV is 0. With ATV=1 and an AT whose bit in AT_MASK is 0, it gives status 5 and leaves the slot unchanged.
- R7: A read-counter command copies the slot into offset 16 as CTR[61:0] (zero above the counter width), INVALID[62] and OVF[63]. The copy takes the value from before any transfer in the same cycle. The register changes only on an accepted read.
- R8: On a transfer pulse, an active slot counts when three conditions hold: the MCID matches; the access type matches, or the slot accepts any; and the direction suits the event (1 = read and write, 2 = reads only, 3 = writes only). Counting adds the byte count and clears INVALID.
- R9: When an addition carries out of the counter width, OVF is set and the count keeps the remainder modulo 2^CTR_W. OVF stays set until the slot is configured again.
- R10: When AT_MASK is 0, AT and ATV are stored and reported as 0.
- R11: A command completes in the cycle of its write, so BUSY always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| xfer_valid | input | 1 | One transfer reported this cycle |
| xfer_wr | input | 1 | Transfer direction: 1 write, 0 read |
| xfer_mon_id | input | 12 | Monitoring ID of the transfer |
| xfer_at | input | 3 | Access type of the transfer |
| xfer_bytes | input | BYTES_W | Bytes moved by the transfer |

## Verification
The hardest state to reach from the ports is a counter wrap. With the default 62-bit count, no run of transfers could ever carry out. The bench therefore builds the block with a 10-bit counter and pushes one slot past 1023 with a few full-size transfers. It then reads back the sticky OVF flag and the remainder, and checks that a later configure clears the flag. A second hard case is a read command and a counted transfer that land on the same slot in the same cycle. The bench drives both in one cycle, then checks that the snapshot shows the old count and a later read shows the new one.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;

  localparam int OP_W   = 5;
  localparam int AT_W   = 3;
  localparam int MCID_W = 12;
  localparam int EVT_W  = 8;
  localparam int ST_W   = 7;

  localparam int CTL_OFF  = 8;
  localparam int CVAL_OFF = 16;

  localparam logic [OP_W-1:0] OP_CONFIG = 5'd1;
  localparam logic [OP_W-1:0] OP_READ   = 5'd2;

  localparam logic [ST_W-1:0] ST_OK      = 7'd1;
  localparam logic [ST_W-1:0] ST_BAD_OP  = 7'd2;
  localparam logic [ST_W-1:0] ST_BAD_ID  = 7'd3;
  localparam logic [ST_W-1:0] ST_BAD_EVT = 7'd4;
  localparam logic [ST_W-1:0] ST_BAD_AT  = 7'd5;

  localparam logic [EVT_W-1:0] EV_OFF = 8'd0;
  localparam logic [EVT_W-1:0] EV_ALL = 8'd1;
  localparam logic [EVT_W-1:0] EV_RD  = 8'd2;
  localparam logic [EVT_W-1:0] EV_WR  = 8'd3;

  // Writable command fields, packed so that bit 0 is OP[0] and bit 28 is ATV.
  typedef struct packed {
    logic              atv;
    logic [EVT_W-1:0]  evt;
    logic [MCID_W-1:0] mcid;
    logic [AT_W-1:0]   at;
    logic [OP_W-1:0]   op;
  } cmd_t;

  typedef enum logic [1:0] {ACT_NONE, ACT_CFG, ACT_OFF, ACT_READ} act_e;

  // Direction rule of a counting event: 1 both, 2 reads, 3 writes.
  function automatic logic dir_selected(input logic [1:0] evt, input logic is_wr);
    case (evt)
      2'd1:    dir_selected = 1'b1;
      2'd2:    dir_selected = !is_wr;
      2'd3:    dir_selected = is_wr;
      default: dir_selected = 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] pack_ctl(input cmd_t c, input logic [ST_W-1:0] st);
    pack_ctl = {24'b0, 1'b0, st, 3'b0, c};
  endfunction

  function automatic logic [63:0] pack_cval(input logic ovf, input logic inv,
                                            input logic [61:0] ctr);
    pack_cval = {ovf, inv, ctr};
  endfunction

endpackage

// File: rtl/bwmon_cmd_check.sv
module bwmon_cmd_check
  import bwmon_pkg::*;
#(
  parameter int         NUM_MON = 16,
  parameter logic [7:0] AT_MASK = 8'h01,
  parameter bit         CFG_EN  = 1'b1,
  parameter bit         READ_EN = 1'b1
) (
  input  cmd_t            raw,
  output cmd_t            cmd,
  output logic [ST_W-1:0] status,
  output act_e            act
);

  logic at_ok;

  always_comb begin
    cmd = raw;
    if (AT_MASK == 8'h00) begin
      cmd.at  = '0;
      cmd.atv = 1'b0;
    end
    at_ok  = AT_MASK[cmd.at];
    status = ST_BAD_OP;
    act    = ACT_NONE;
    if (32'(cmd.mcid) >= 32'(NUM_MON)) begin
      status = ST_BAD_ID;
    end else if (cmd.op == OP_CONFIG && CFG_EN) begin
      if (cmd.evt == EV_OFF) begin
        status = ST_OK;
        act    = ACT_OFF;
      end else if (cmd.evt <= EV_WR) begin
        if (cmd.atv && !at_ok) begin
          status = ST_BAD_AT;
        end else begin
          status = ST_OK;
          act    = ACT_CFG;
        end
      end else begin
        status = ST_BAD_EVT;
      end
    end else if (cmd.op == OP_READ && READ_EN) begin
      status = ST_OK;
      act    = ACT_READ;
    end
  end

endmodule

// File: rtl/bwmon_slot.sv
module bwmon_slot
  import bwmon_pkg::*;
#(
  parameter int CTR_W   = 62,
  parameter int BYTES_W = 16,
  parameter int SLOT_ID = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg,
  input  logic               off,
  input  logic [1:0]         cfg_evt,
  input  logic               cfg_any,
  input  logic [AT_W-1:0]    cfg_at,
  input  logic               xfer_valid,
  input  logic               xfer_wr,
  input  logic [MCID_W-1:0]  xfer_id,
  input  logic [AT_W-1:0]    xfer_at,
  input  logic [BYTES_W-1:0] xfer_bytes,
  output logic               active,
  output logic [CTR_W-1:0]   ctr,
  output logic               inval,
  output logic               ovf,
  output logic               wrap
);

  logic [1:0]      evt_q;
  logic            any_q;
  logic [AT_W-1:0] at_q;
  logic            hit;
  logic            carry;
  logic [CTR_W-1:0] sum;

  assign hit = xfer_valid && active && (xfer_id == MCID_W'(SLOT_ID))
            && dir_selected(evt_q, xfer_wr) && (any_q || at_q == xfer_at);
  assign {carry, sum} = {1'b0, ctr} + (CTR_W+1)'(xfer_bytes);
  assign wrap = hit && !cfg && !off && carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      evt_q  <= 2'd0;
      any_q  <= 1'b0;
      at_q   <= '0;
      ctr    <= '0;
      inval  <= 1'b0;
      ovf    <= 1'b0;
    end else if (cfg) begin
      active <= 1'b1;
      evt_q  <= cfg_evt;
      any_q  <= cfg_any;
      at_q   <= cfg_at;
      ctr    <= '0;
      inval  <= 1'b1;
      ovf    <= 1'b0;
    end else if (off) begin
      active <= 1'b0;
    end else if (hit) begin
      ctr   <= sum;
      inval <= 1'b0;
      if (carry) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/bwmon_ctrl.sv
module bwmon_ctrl
  import bwmon_pkg::*;
#(
  parameter int         NUM_MON = 16,
  parameter int         CTR_W   = 62,
  parameter int         BYTES_W = 16,
  parameter int         ADDR_W  = 12,
  parameter logic [7:0] AT_MASK = 8'h01,
  parameter bit         CFG_EN  = 1'b1,
  parameter bit         READ_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  input  logic               xfer_valid,
  input  logic               xfer_wr,
  input  logic [11:0]        xfer_mon_id,
  input  logic [2:0]         xfer_at,
  input  logic [BYTES_W-1:0] xfer_bytes
);

  logic [63:0] ctl_q;
  logic [63:0] ctr_val_q;
  logic        ctl_wr;
  cmd_t        cmd;
  logic [ST_W-1:0] status;
  act_e        act;

  logic [NUM_MON-1:0] slot_cfg;
  logic [NUM_MON-1:0] slot_off;
  logic [NUM_MON-1:0] slot_active;
  logic [NUM_MON-1:0] slot_inval;
  logic [NUM_MON-1:0] slot_ovf;
  logic [NUM_MON-1:0] slot_wrap;
  logic [CTR_W-1:0]   slot_ctr [NUM_MON];
  logic [63:0]        snap;

  logic unused_hi;
  assign unused_hi = ^{reg_wdata[63:29], slot_active};

  assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(CTL_OFF));

  bwmon_cmd_check #(
    .NUM_MON(NUM_MON), .AT_MASK(AT_MASK), .CFG_EN(CFG_EN), .READ_EN(READ_EN)
  ) u_check (
    .raw   (cmd_t'(reg_wdata[28:0])),
    .cmd   (cmd),
    .status(status),
    .act   (act)
  );

  for (genvar i = 0; i < NUM_MON; i++) begin : g_slot
    assign slot_cfg[i] = ctl_wr && act == ACT_CFG && cmd.mcid == MCID_W'(i);
    assign slot_off[i] = ctl_wr && act == ACT_OFF && cmd.mcid == MCID_W'(i);

    bwmon_slot #(.CTR_W(CTR_W), .BYTES_W(BYTES_W), .SLOT_ID(i)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (slot_cfg[i]),
      .off       (slot_off[i]),
      .cfg_evt   (cmd.evt[1:0]),
      .cfg_any   (!cmd.atv),
      .cfg_at    (cmd.at),
      .xfer_valid(xfer_valid),
      .xfer_wr   (xfer_wr),
      .xfer_id   (xfer_mon_id),
      .xfer_at   (xfer_at),
      .xfer_bytes(xfer_bytes),
      .active    (slot_active[i]),
      .ctr       (slot_ctr[i]),
      .inval     (slot_inval[i]),
      .ovf       (slot_ovf[i]),
      .wrap      (slot_wrap[i])
    );
  end

  // Slot chosen by the command, shaped as the counter-value register.
  always_comb begin
    snap = '0;
    for (int i = 0; i < NUM_MON; i++) begin
      if (cmd.mcid == MCID_W'(i))
        snap = pack_cval(slot_ovf[i], slot_inval[i], 62'(slot_ctr[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      ctr_val_q <= '0;
    end else if (ctl_wr) begin
      ctl_q <= pack_ctl(cmd, status);
      if (act == ACT_READ) ctr_val_q <= snap;
    end
  end

  always_comb begin
    if (reg_addr == ADDR_W'(CTL_OFF))       reg_rdata = ctl_q;
    else if (reg_addr == ADDR_W'(CVAL_OFF)) reg_rdata = ctr_val_q;
    else                                    reg_rdata = '0;
  end

endmodule

// File: rtl/bwmon_ctrl_chk.sv
module bwmon_ctrl_chk #(
  parameter int NUM_MON = 16,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [11:0]        wr_mcid,
  input logic [6:0]         ctl_status,
  input logic               ctl_busy,
  input logic [63:0]        ctr_val_q,
  input logic [NUM_MON-1:0] slot_ovf,
  input logic [NUM_MON-1:0] slot_cfg,
  input logic [NUM_MON-1:0] slot_wrap
);

  logic wr_ctl;
  assign wr_ctl = reg_wr && reg_addr == ADDR_W'(8);

  assert_busy_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_busy);

  assert_bad_id_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && 32'(wr_mcid) >= 32'(NUM_MON)) |=> ctl_status == 7'd3);

  assert_status_coded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl_status >= 7'd1 && ctl_status <= 7'd5));

  assert_cval_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable(ctr_val_q));

  for (genvar i = 0; i < NUM_MON; i++) begin : g_ovf
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_ovf[i] && !slot_cfg[i]) |=> slot_ovf[i]);
    assert_wrap_sets_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
      slot_wrap[i] |=> slot_ovf[i]);
    assert_cfg_clears_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
      slot_cfg[i] |=> !slot_ovf[i]);
  end

endmodule

bind bwmon_ctrl bwmon_ctrl_chk #(.NUM_MON(NUM_MON), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .wr_mcid   (reg_wdata[19:8]),
  .ctl_status(ctl_q[38:32]),
  .ctl_busy  (ctl_q[39]),
  .ctr_val_q (ctr_val_q),
  .slot_ovf  (slot_ovf),
  .slot_cfg  (slot_cfg),
  .slot_wrap (slot_wrap)
);

// File: tb/bwmon_ctrl_bench.sv
module bwmon_ctrl_bench;

  localparam int NM = 4;
  localparam int CW = 10;
  localparam int BW = 8;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic          noat_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0]   reg_wdata = '0;
  logic [63:0]   reg_rdata;
  logic [63:0]   noat_rdata;
  logic          xfer_valid = 1'b0;
  logic          xfer_wr = 1'b0;
  logic [11:0]   xfer_mon_id = '0;
  logic [2:0]    xfer_at = '0;
  logic [BW-1:0] xfer_bytes = '0;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  bwmon_ctrl #(.NUM_MON(NM), .CTR_W(CW), .BYTES_W(BW), .ADDR_W(AW), .AT_MASK(8'h01))
  u_bwmon_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_valid(xfer_valid),
    .xfer_wr(xfer_wr), .xfer_mon_id(xfer_mon_id), .xfer_at(xfer_at),
    .xfer_bytes(xfer_bytes)
  );

  bwmon_ctrl #(.NUM_MON(NM), .CTR_W(CW), .BYTES_W(BW), .ADDR_W(AW), .AT_MASK(8'h00))
  u_noat (
    .clk(clk), .rst_n(rst_n), .reg_wr(noat_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(noat_rdata), .xfer_valid(1'b0),
    .xfer_wr(1'b0), .xfer_mon_id(12'd0), .xfer_at(3'd0), .xfer_bytes(8'd0)
  );

  // {op[5], at[3], mcid[12], evt[8], atv[1], expected status[7]}
  localparam logic [35:0] VEC [12] = '{
    {5'd1, 3'd0, 12'd0, 8'd1, 1'b0, 7'd1},
    {5'd1, 3'd0, 12'd1, 8'd2, 1'b1, 7'd1},
    {5'd1, 3'd1, 12'd2, 8'd3, 1'b1, 7'd5},
    {5'd1, 3'd1, 12'd2, 8'd3, 1'b0, 7'd1},
    {5'd1, 3'd0, 12'd4, 8'd1, 1'b0, 7'd3},
    {5'd7, 3'd0, 12'd4, 8'd0, 1'b0, 7'd3},
    {5'd7, 3'd0, 12'd0, 8'd0, 1'b0, 7'd2},
    {5'd0, 3'd0, 12'd0, 8'd0, 1'b0, 7'd2},
    {5'd1, 3'd0, 12'd3, 8'd9, 1'b0, 7'd4},
    {5'd1, 3'd0, 12'd3, 8'd0, 1'b0, 7'd1},
    {5'd2, 3'd0, 12'd0, 8'd0, 1'b0, 7'd1},
    {5'd1, 3'd5, 12'd3, 8'd4, 1'b1, 7'd4}
  };

  function automatic logic [63:0] cmd_word(input int op, input int at, input int mcid,
                                           input int evt, input int atv);
    return (64'(op) & 64'h1F) | ((64'(at) & 64'h7) << 5) | ((64'(mcid) & 64'hFFF) << 8)
         | ((64'(evt) & 64'hFF) << 20) | ((64'(atv) & 64'h1) << 28);
  endfunction

  function automatic logic [63:0] ctl_word(input int op, input int at, input int mcid,
                                           input int evt, input int atv, input int st);
    return cmd_word(op, at, mcid, evt, atv) | ((64'(st) & 64'h7F) << 32);
  endfunction

  function automatic logic [63:0] cval(input int ovf, input int inv, input int ctr);
    return (64'(ovf) << 63) | (64'(inv) << 62) | 64'(ctr);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int addr, input logic [63:0] data);
    @(negedge clk);
    reg_addr  = AW'(addr);
    reg_wdata = data;
    reg_wr    = 1'b1;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd_reg(input int addr, output logic [63:0] data);
    reg_addr = AW'(addr);
    #1;
    data = reg_rdata;
  endtask

  task automatic xfer(input int id, input logic wr, input int at, input int bytes);
    @(negedge clk);
    xfer_mon_id = 12'(id);
    xfer_wr     = wr;
    xfer_at     = 3'(at);
    xfer_bytes  = BW'(bytes);
    xfer_valid  = 1'b1;
    @(negedge clk);
    xfer_valid  = 1'b0;
  endtask

  task automatic read_slot(input int id, output logic [63:0] data);
    wr_reg(8, cmd_word(2, 0, id, 0, 0));
    rd_reg(16, data);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [63:0] v;
    logic [63:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd_reg(8, v);  check("R1 control after reset", v, 64'd0);
    rd_reg(16, v); check("R1 counter value after reset", v, 64'd0);

    // Vector table: command word, readback and status (R3 R4 R5 R6).
    for (int k = 0; k < 12; k++) begin
      int op, at, mcid, evt, atv, st;
      op   = int'(VEC[k][35:31]);
      at   = int'(VEC[k][30:28]);
      mcid = int'(VEC[k][27:16]);
      evt  = int'(VEC[k][15:8]);
      atv  = int'(VEC[k][7]);
      st   = int'(VEC[k][6:0]);
      wr_reg(8, cmd_word(op, at, mcid, evt, atv));
      rd_reg(8, v);
      check($sformatf("R4 table vector %0d", k), v, ctl_word(op, at, mcid, evt, atv, st));
    end

    // Fresh configure: count 0 and INVALID set.
    read_slot(0, v); check("R6 configured slot reads INVALID", v, cval(0, 1, 0));

    // Slot 0 counts both directions, any access type.
    xfer(0, 1'b0, 0, 10);
    xfer(0, 1'b1, 1, 5);
    read_slot(0, v); check("R8 read+write event sums both", v, cval(0, 0, 15));

    // Slot 1: reads only, access type 0 only.
    xfer(1, 1'b1, 0, 7);
    xfer(1, 1'b0, 1, 3);
    xfer(1, 1'b0, 0, 4);
    read_slot(1, v); check("R8 read-only event with AT filter", v, cval(0, 0, 4));

    // Slot 2: writes only, any access type (ATV=0 after the rejected status-5 try).
    xfer(2, 1'b0, 0, 9);
    xfer(2, 1'b1, 1, 6);
    read_slot(2, v); check("R6 R8 write-only slot after rejected AT", v, cval(0, 0, 6));

    // Slot 3 was deactivated and never configured.
    xfer(3, 1'b0, 0, 20);
    read_slot(3, v); check("R5 inactive slot counts nothing", v, cval(0, 0, 0));

    // Out-of-range MCID read leaves counter-value register untouched.
    wr_reg(8, cmd_word(2, 0, 9, 0, 0));
    rd_reg(16, v); check("R3 bad MCID read keeps counter value", v, cval(0, 0, 0));

    // Wrap of a 10-bit counter: 15 + 4*255 = 1035 -> 11 with OVF.
    for (int k = 0; k < 4; k++) xfer(0, 1'b0, 0, 255);
    read_slot(0, v); check("R9 wrap sets OVF and keeps remainder", v, cval(1, 0, 11));
    xfer(0, 1'b1, 0, 1);
    read_slot(0, v); check("R9 OVF sticky while counting", v, cval(1, 0, 12));
    wr_reg(8, cmd_word(1, 0, 0, 1, 0));
    read_slot(0, v); check("R9 reconfigure clears OVF", v, cval(0, 1, 0));

    // Read command and counted transfer in the same cycle on slot 1.
    @(negedge clk);
    reg_addr    = AW'(8);
    reg_wdata   = cmd_word(2, 0, 1, 0, 0);
    reg_wr      = 1'b1;
    xfer_mon_id = 12'd1;
    xfer_wr     = 1'b0;
    xfer_at     = 3'd0;
    xfer_bytes  = 8'd2;
    xfer_valid  = 1'b1;
    @(negedge clk);
    reg_wr      = 1'b0;
    xfer_valid  = 1'b0;
    rd_reg(16, v); check("R7 snapshot taken before same-cycle transfer", v, cval(0, 0, 4));
    read_slot(1, v); check("R7 later read shows the transfer", v, cval(0, 0, 6));

    // Read-only and unmapped offsets.
    rd_reg(16, keep);
    wr_reg(16, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(16, v); check("R2 write to counter value dropped", v, keep);
    wr_reg(32, 64'hFFFF_FFFF_FFFF_FFFF);
    rd_reg(8, v);  check("R2 unmapped write leaves control", v, ctl_word(2, 0, 1, 0, 0, 1));
    wr_reg(12, cmd_word(1, 0, 1, 1, 0));
    rd_reg(16, v); check("R2 unaligned write does nothing", v, keep);
    rd_reg(24, v); check("R2 unmapped offset reads zero", v, 64'd0);
    rd_reg(12, v); check("R2 unaligned offset reads zero", v, 64'd0);
    rd_reg(0, v);  check("R2 offset 0 reads zero", v, 64'd0);

    // Read-only STATUS/BUSY and reserved bits ignore written ones.
    wr_reg(8, 64'hFFFF_FFFF_E000_0000 | cmd_word(2, 0, 2, 0, 0));
    rd_reg(8, v);  check("R11 BUSY and STATUS not writable", v, ctl_word(2, 0, 2, 0, 0, 1));

    // Instance without access types forces AT and ATV to 0.
    @(negedge clk);
    reg_addr  = AW'(8);
    reg_wdata = cmd_word(1, 3, 0, 1, 1);
    noat_wr   = 1'b1;
    @(negedge clk);
    noat_wr   = 1'b0;
    #1;
    check("R10 AT and ATV forced to zero", noat_rdata, ctl_word(1, 0, 0, 1, 0, 1));

    finish_run();
  end

endmodule